// File: doc/BRIEF.md
# Byte/Word Arithmetic Logic Unit with Status Flags

This block is the integer execution unit of a small 16-bit processor core. It does two's-complement addition and subtraction, with and without an incoming carry, and also does bitwise logic and single-bit shifts. Two operands, an operation code, a size select and an external carry-in go in. The result comes out combinationally in the same cycle. Five status flags are held in a register.

The flags are Carry, Zero, Negative, Overflow and Digit Carry. Every flag is taken at the selected width: the low byte in byte mode, the full word in word mode. On subtraction the carry flags work as inverted borrows, so 1 means no borrow occurred. Each operation class updates only its own subset of the flags. The register loads only in a cycle where the flag-update enable is high.

Top module: `bw_alu`

## Requirements
- R1: Operation codes are ADD=0, ADDC=1, SUB=2, SUBB=3, AND=4, OR=5, XOR=6, NOT=7, SHL=8, SHR=9 and ASR=10. ADD gives opA+opB, and ADDC gives opA+opB+carryIn, both modulo 2^width.
- R2: SUB gives opA-opB, and SUBB gives opA-opB-(1-carryIn). For both, flag C is 1 when no borrow leaves the top bit and 0 when one does, and flag DC is 1 when no borrow leaves bit 3.
- R3: For arithmetic codes (0..3), flag C is the carry out of the top bit of the selected width, and flag DC is the carry out of bit 3. Flag OV is 1 when both addends have the same sign and the result sign differs. For subtraction the subtrahend is inverted before this test.
- R4: When byteMode is 1, result[15:8] is 0, only bits 7:0 are computed, and bit 7 is the top bit for every flag and shift. When byteMode is 0, bit 15 is the top bit.
- R5: For every assigned code, flag Z is 1 exactly when the sized result is 0, and flag N equals the top bit of the sized result.
- R6: Logic codes 4..7 produce opA&opB, opA|opB, opA^opB and ~opA. They update only N and Z, and leave C, OV and DC unchanged.
- R7: SHL shifts left and fills with 0. SHR shifts right and fills with 0. ASR shifts right and repeats the top bit. Each shifts by one bit, and C receives the bit shifted out. OV and DC are unchanged.
- R8: When flagEn is 0, no flag changes on the clock edge. When flagEn is 1, the flags take the new values in the cycle after the operation is presented.
- R9: Asynchronous reset (rstN low) clears all five flags to 0.
- R10: Codes 11..15 produce result 0 and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Operation code |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| byteMode | input | 1 | 1 selects 8-bit operation, 0 selects 16-bit |
| carryIn | input | 1 | External carry used by ADDC and SUBB |
| flagEn | input | 1 | Allows the flag register to load |
| result | output | 16 | Combinational result |
| flagC | output | 1 | Carry / inverted borrow flag |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |
| flagOv | output | 1 | Signed overflow flag |
| flagDc | output | 1 | Digit carry / inverted digit borrow flag |

## Verification
Some rules hold on every cycle, and the checker tests these continuously:
- the flags hold when flagEn is low or the code is unassigned;
- logic and shift operations leave the untouched flags alone;
- the upper byte is zero in byte mode;
- Z and N follow the sized result of the previous cycle.

The bench sweeps every operation code at both sizes, both carry-in values and many corner operands to show the values themselves. These are the sums, the differences with borrow, the overflow cases at the sign boundaries, the digit carries and the shifted-out bits, all compared with figures the bench computes arithmetically.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

  localparam int NFLAGS = 5;
  localparam int FC  = 0;
  localparam int FZ  = 1;
  localparam int FN  = 2;
  localparam int FOV = 3;
  localparam int FDC = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOT  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_ASR  = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_EXT} cin_sel_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOT} logic_op_e;
  typedef enum logic [1:0] {SH_LEFT, SH_RIGHT, SH_ARITH} shift_op_e;

  typedef struct packed {
    logic              arithEn;
    logic              invB;
    cin_sel_e          cinSel;
    logic              logicEn;
    logic_op_e         logicOp;
    logic              shiftEn;
    shift_op_e         shiftOp;
    logic [NFLAGS-1:0] updMask;
  } alu_strobe_t;

endpackage

// File: rtl/bw_alu_ctrl.sv
module bw_alu_ctrl
  import bw_alu_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic [OPW-1:0] opcode,
  output alu_strobe_t    strb
);

  localparam logic [NFLAGS-1:0] MASK_ALL   = {NFLAGS{1'b1}};
  localparam logic [NFLAGS-1:0] MASK_NZ    = NFLAGS'((1 << FN) | (1 << FZ));
  localparam logic [NFLAGS-1:0] MASK_SHIFT = NFLAGS'((1 << FN) | (1 << FZ) | (1 << FC));

  always_comb begin
    strb = '0;
    strb.cinSel  = CIN_ZERO;
    strb.logicOp = LG_AND;
    strb.shiftOp = SH_LEFT;
    unique case (opcode)
      OP_ADD:  begin strb.arithEn = 1'b1; strb.updMask = MASK_ALL; end
      OP_ADDC: begin strb.arithEn = 1'b1; strb.cinSel = CIN_EXT; strb.updMask = MASK_ALL; end
      OP_SUB:  begin strb.arithEn = 1'b1; strb.invB = 1'b1; strb.cinSel = CIN_ONE; strb.updMask = MASK_ALL; end
      OP_SUBB: begin strb.arithEn = 1'b1; strb.invB = 1'b1; strb.cinSel = CIN_EXT; strb.updMask = MASK_ALL; end
      OP_AND:  begin strb.logicEn = 1'b1; strb.logicOp = LG_AND; strb.updMask = MASK_NZ; end
      OP_OR:   begin strb.logicEn = 1'b1; strb.logicOp = LG_OR;  strb.updMask = MASK_NZ; end
      OP_XOR:  begin strb.logicEn = 1'b1; strb.logicOp = LG_XOR; strb.updMask = MASK_NZ; end
      OP_NOT:  begin strb.logicEn = 1'b1; strb.logicOp = LG_NOT; strb.updMask = MASK_NZ; end
      OP_SHL:  begin strb.shiftEn = 1'b1; strb.shiftOp = SH_LEFT;  strb.updMask = MASK_SHIFT; end
      OP_SHR:  begin strb.shiftEn = 1'b1; strb.shiftOp = SH_RIGHT; strb.updMask = MASK_SHIFT; end
      OP_ASR:  begin strb.shiftEn = 1'b1; strb.shiftOp = SH_ARITH; strb.updMask = MASK_SHIFT; end
      default: strb = strb; // unassigned codes: no unit, no flag update (R10)
    endcase
  end

endmodule

// File: rtl/bw_alu_dp.sv
module bw_alu_dp
  import bw_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  alu_strobe_t       strb,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              byteMode,
  input  logic              carryIn,
  output logic [WIDTH-1:0]  result,
  output logic [NFLAGS-1:0] flagD
);

  localparam int HALF = WIDTH / 2;
  localparam logic [WIDTH-1:0] MASK_BYTE = {{(WIDTH-HALF){1'b0}}, {HALF{1'b1}}};
  localparam logic [WIDTH-1:0] MASK_WORD = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] TOP_BYTE  = WIDTH'(1) << (HALF-1);
  localparam logic [WIDTH-1:0] TOP_WORD  = WIDTH'(1) << (WIDTH-1);

  logic [WIDTH-1:0] sizeMask, topBit, aSized, bEff;
  logic [WIDTH:0]   sumW;
  logic             cinEff;
  logic [WIDTH-1:0] logicRes, shiftRes, rawRes;
  logic             msbA, msbB, msbR, arithCarry, digitCarry, shiftCarry, ovf;

  assign sizeMask = byteMode ? MASK_BYTE : MASK_WORD;
  assign topBit   = byteMode ? TOP_BYTE  : TOP_WORD;
  assign aSized   = opA & sizeMask;

  // adder: subtraction adds the inverted subtrahend
  assign bEff = strb.invB ? ~opB : opB;
  always_comb begin
    unique case (strb.cinSel)
      CIN_ONE: cinEff = 1'b1;
      CIN_EXT: cinEff = carryIn;
      default: cinEff = 1'b0;
    endcase
  end
  assign sumW = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, cinEff};

  // carry into a bit position = a ^ b ^ sum at that position
  assign digitCarry = opA[4] ^ bEff[4] ^ sumW[4];
  assign arithCarry = byteMode ? (opA[HALF] ^ bEff[HALF] ^ sumW[HALF]) : sumW[WIDTH];

  assign msbA = |(opA & topBit);
  assign msbB = |(bEff & topBit);
  assign msbR = |(sumW[WIDTH-1:0] & topBit);
  assign ovf  = (msbA == msbB) && (msbR != msbA);

  always_comb begin
    unique case (strb.logicOp)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = ~opA;
    endcase
  end

  always_comb begin
    unique case (strb.shiftOp)
      SH_LEFT: begin
        shiftRes   = aSized << 1;
        shiftCarry = msbA;
      end
      SH_RIGHT: begin
        shiftRes   = aSized >> 1;
        shiftCarry = opA[0];
      end
      default: begin
        shiftRes   = (aSized >> 1) | (msbA ? topBit : '0);
        shiftCarry = opA[0];
      end
    endcase
  end

  always_comb begin
    if (strb.arithEn)      rawRes = sumW[WIDTH-1:0];
    else if (strb.logicEn) rawRes = logicRes;
    else if (strb.shiftEn) rawRes = shiftRes;
    else                   rawRes = '0;
  end

  assign result = rawRes & sizeMask;

  always_comb begin
    flagD      = '0;
    flagD[FZ]  = (result == '0);
    flagD[FN]  = |(result & topBit);
    flagD[FC]  = strb.shiftEn ? shiftCarry : arithCarry;
    flagD[FOV] = ovf;
    flagD[FDC] = digitCarry;
  end

endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int OPW   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPW-1:0]   opcode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             byteMode,
  input  logic             carryIn,
  input  logic             flagEn,
  output logic [WIDTH-1:0] result,
  output logic             flagC,
  output logic             flagZ,
  output logic             flagN,
  output logic             flagOv,
  output logic             flagDc
);

  alu_strobe_t       strb;
  logic [NFLAGS-1:0] flagD, flagQ;

  bw_alu_ctrl #(.OPW(OPW)) ctrl_i (
    .opcode (opcode),
    .strb   (strb)
  );

  bw_alu_dp #(.WIDTH(WIDTH)) dp_i (
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .byteMode (byteMode),
    .carryIn  (carryIn),
    .result   (result),
    .flagD    (flagD)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else if (flagEn) begin
      for (int i = 0; i < NFLAGS; i++) begin
        if (strb.updMask[i]) flagQ[i] <= flagD[i];
      end
    end
  end

  assign flagC  = flagQ[FC];
  assign flagZ  = flagQ[FZ];
  assign flagN  = flagQ[FN];
  assign flagOv = flagQ[FOV];
  assign flagDc = flagQ[FDC];

endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk #(
  parameter int WIDTH = 16,
  parameter int OPW   = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [OPW-1:0]   opcode,
  input logic             byteMode,
  input logic             flagEn,
  input logic [WIDTH-1:0] result,
  input logic             flagC,
  input logic             flagZ,
  input logic             flagN,
  input logic             flagOv,
  input logic             flagDc
);

  localparam int HALF = WIDTH / 2;
  logic [4:0] flagsNow;
  logic       topNow;
  assign flagsNow = {flagDc, flagOv, flagN, flagZ, flagC};
  assign topNow   = byteMode ? result[HALF-1] : result[WIDTH-1];

  AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !flagEn |=> $stable(flagsNow)); // R8

  AST_UNASSIGNED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opcode > OPW'(10)) |=> $stable(flagsNow)); // R10

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    byteMode |-> (result[WIDTH-1:HALF] == '0)); // R4

  AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (flagEn && opcode <= OPW'(10)) |=> (flagZ == ($past(result) == '0))); // R5

  AST_NEG_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (flagEn && opcode <= OPW'(10)) |=> (flagN == $past(topNow))); // R5

  AST_LOGIC_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (opcode >= OPW'(4) && opcode <= OPW'(7)) |=>
      ($stable(flagC) && $stable(flagOv) && $stable(flagDc))); // R6

  AST_SHIFT_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (opcode >= OPW'(8) && opcode <= OPW'(10)) |=> ($stable(flagOv) && $stable(flagDc))); // R7

endmodule

bind bw_alu bw_alu_chk #(.WIDTH(WIDTH), .OPW(OPW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .opcode   (opcode),
  .byteMode (byteMode),
  .flagEn   (flagEn),
  .result   (result),
  .flagC    (flagC),
  .flagZ    (flagZ),
  .flagN    (flagN),
  .flagOv   (flagOv),
  .flagDc   (flagDc)
);

// File: tb/bw_alu_tb_top.sv
module bw_alu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opcode = '0;
  logic [15:0] opA = '0, opB = '0;
  logic        byteMode = 1'b0, carryIn = 1'b0, flagEn = 1'b0;
  logic [15:0] result;
  logic        flagC, flagZ, flagN, flagOv, flagDc;

  int nChecks = 0;
  int nFails  = 0;
  logic [4:0] expFlags = '0; // {DC, OV, N, Z, C}
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  bw_alu dut_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .opA(opA), .opB(opB),
    .byteMode(byteMode), .carryIn(carryIn), .flagEn(flagEn), .result(result),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagOv(flagOv), .flagDc(flagDc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s op=%0d a=%h b=%h byte=%0b cin=%0b en=%0b actual=%h expected=%h",
               tag, opcode, opA, opB, byteMode, carryIn, flagEn, act, exp);
    end
  endtask

  function automatic logic [15:0] corner(input int k);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h000F;  3: return 16'h0010;
      4: return 16'h007F;  5: return 16'h0080;  6: return 16'h00FF;  7: return 16'h0F0F;
      8: return 16'h7FFF;  9: return 16'h8000; 10: return 16'h8001; 11: return 16'hFFFF;
      12: return 16'h5A5A; 13: return 16'hA5C3; 14: return 16'h1234; default: return 16'hFFFE;
    endcase
  endfunction

  // reference model: returns result, new flags and update mask
  task automatic model(input int op, input int a, input int b, input bit bm, input bit ci,
                       output int res, output logic [4:0] nf, output logic [4:0] msk);
    int w, mask, ax, bx, cx, s, sa, sb, sr;
    w = bm ? 8 : 16;
    mask = (1 << w) - 1;
    ax = a & mask;
    nf = '0; msk = '0; res = 0;
    if (op <= 3) begin
      bx = (op >= 2) ? (~b & mask) : (b & mask);
      cx = (op == 0) ? 0 : (op == 2) ? 1 : int'(ci);
      s = ax + bx + cx;
      res = s & mask;
      nf[0] = ((s >> w) & 1) != 0;
      nf[4] = (((ax & 15) + (bx & 15) + cx) >> 4) != 0;
      sa = (ax >> (w-1)) & 1; sb = (bx >> (w-1)) & 1; sr = (res >> (w-1)) & 1;
      nf[3] = (sa == sb) && (sr != sa);
      msk = 5'b11111;
    end else if (op <= 7) begin
      case (op)
        4: res = a & b & mask;
        5: res = (a | b) & mask;
        6: res = (a ^ b) & mask;
        default: res = ~a & mask;
      endcase
      msk = 5'b00110;
    end else if (op <= 10) begin
      sa = (ax >> (w-1)) & 1;
      if (op == 8) begin res = (ax << 1) & mask; nf[0] = sa != 0; end
      else if (op == 9) begin res = ax >> 1; nf[0] = (a & 1) != 0; end
      else begin res = (ax >> 1) | (sa << (w-1)); nf[0] = (a & 1) != 0; end
      msk = 5'b00111;
    end
    nf[1] = (res == 0);
    nf[2] = ((res >> (w-1)) & 1) != 0;
  endtask

  function automatic string tagFor(input int op, input bit bm);
    string t;
    if (op <= 1) t = "R1";
    else if (op <= 3) t = "R2/R3";
    else if (op <= 7) t = "R6";
    else if (op <= 10) t = "R7";
    else t = "R10";
    if (bm) t = {t, "/R4"};
    return t;
  endfunction

  task automatic doOp(input int op, input logic [15:0] a, input logic [15:0] b,
                      input bit bm, input bit ci, input bit en);
    int res;
    logic [4:0] nf, msk;
    @(negedge clk);
    opcode = 4'(op); opA = a; opB = b; byteMode = bm; carryIn = ci; flagEn = en;
    #1;
    model(op, a, b, bm, ci, res, nf, msk);
    check(result == 16'(res), {tagFor(op, bm), " result"}, 32'(result), 32'(res));
    if (en) expFlags = (expFlags & ~msk) | (nf & msk);
    @(negedge clk);
    // flags changed at the intervening edge; Z/N per R5, hold when disabled per R8
    check({flagDc, flagOv, flagN, flagZ, flagC} == expFlags,
          en ? {tagFor(op, bm), "/R5 flags"} : "R8 flags held",
          32'({flagDc, flagOv, flagN, flagZ, flagC}), 32'(expFlags));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R9: flags cleared by reset
    check({flagDc, flagOv, flagN, flagZ, flagC} == 5'b0, "R9 reset flags",
          32'({flagDc, flagOv, flagN, flagZ, flagC}), 32'd0);
    rstN = 1'b1;
    for (int op = 0; op < 16; op++) begin
      for (int bm = 0; bm < 2; bm++) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j += 3) begin
              doOp(op, corner(i), corner(j), bit'(bm), bit'(ci), ((i + j + op) % 3) != 0);
            end
          end
        end
      end
    end
    // R9: reset mid-run clears flags set by an operation
    doOp(0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    rstN = 1'b0; #1;
    expFlags = '0;
    check({flagDc, flagOv, flagN, flagZ, flagC} == 5'b0, "R9 async reset",
          32'({flagDc, flagOv, flagN, flagZ, flagC}), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule